// File: doc/BRIEF.md
# Four-Channel Open-Drain PWM DAC with Port Fallback

This block drives four open-drain pins. Each pin either serves as a plain output bit or carries a pulse-width-modulated signal that an external pull-up and filter turn into an analog level. A single free-running period counter, 512 clock cycles long, is shared by all channels. The period is about 114 µs with a 4.5 MHz clock. A duty write names one channel and lands in that channel's shadow register. The value moves to the active register only when the period counter wraps, so the previous duty can keep driving the pin for up to one full period.

A per-pin function register selects port use or PWM use. A port data register holds the plain output bits. A pin in PWM mode pulls low while the counter is below its active duty. A pin in port mode pulls low when its port bit is 0. After reset every pin is a port bit in the released (high, transistor off) state.

Top module: `pwm_dac4`

## Requirements
- R1: The period counter steps by one each clock from 0 after reset and wraps from 511 to 0, giving a PWM period of exactly 512 cycles.
- R2: While reset is asserted and right after it, every pin is released (`pull_low` = 0), every function bit is 0 (port use), every port bit is 1, and every duty register is 0.
- R3: A duty write with `duty_wr` = 1 changes only the shadow register of the channel whose index is on `duty_ch`. The other channels keep their duty.
- R4: A written duty becomes active on the first counter wrap (511 to 0) after the write's clock edge. Until then the old duty keeps driving the pin. A write made in the cycle where the counter is 511 waits for the following wrap.
- R5: In PWM mode a pin pulls low in exactly those cycles where the counter is below its active duty, so a duty of D gives D low cycles per period. A duty of 0 never pulls low.
- R6: An active duty of 511 (all ones) holds the pin low for all 512 cycles of the period.
- R7: Function bit value 1 selects PWM and 0 selects port use, with bit i belonging to pin i. `func_wr` loads all four bits, and the new function applies from the next cycle using the channel's current active duty, with no wait for a boundary.
- R8: In port mode, port bit value 0 pulls the pin low and value 1 releases it. `port_wr` loads all four bits, and the new level appears on the next cycle.
- R9: A port write to a pin in PWM mode does not change that pin's output. The bit is still stored and appears once the pin returns to port mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 4.5 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_wr | input | 1 | Duty write strobe |
| duty_ch | input | 2 | Channel index for a duty write |
| duty_val | input | 9 | Duty value to load |
| func_wr | input | 1 | Function register write strobe |
| func_val | input | 4 | New function bits, 1 = PWM, 0 = port |
| port_wr | input | 1 | Port data register write strobe |
| port_val | input | 4 | New port bits, 0 = pull low, 1 = release |
| pull_low | output | 4 | Open-drain drive, 1 = transistor on (pin low) |

## Verification
The embedded assertions check on every cycle that the counter only ever steps by one and wraps, that an active duty changes only at a wrap and then to the shadow value, that duty 0 and duty 511 give a constant output, and that a port-mode pin holds its level when nothing is written. The bench's scenarios are needed to show that the write lands on the right channel, that the low-cycle count per period matches the duty, that a write in the wrap cycle is deferred, and that a port bit written during PWM use shows up after the pin switches back. A lockstep model compares every pin on every cycle while random writes run.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
    typedef enum logic {
        FN_PORT = 1'b0,
        FN_PWM  = 1'b1
    } pin_fn_e;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = (st_q.cnt == {CNT_W{1'b1}});

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == CNT_W'($past(cnt) + 1'b1));
    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan #(
    parameter int DUTY_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DUTY_W-1:0] load_val,
    input  logic [DUTY_W-1:0] cnt,
    input  logic              wrap,
    output logic              pwm_low
);
    localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};

    typedef struct packed {
        logic [DUTY_W-1:0] shadow;
        logic [DUTY_W-1:0] active;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap) st_d.active = st_q.shadow;
        if (load) st_d.shadow = load_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_low = (st_q.active == DUTY_MAX) || (cnt < st_q.active);

    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && $past(rst_n)) |=> $stable(st_q.active));
    // R4
    act_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.active == $past(st_q.shadow));
    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == '0) |-> !pwm_low);
    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == DUTY_MAX) |-> pwm_low);
endmodule

// File: rtl/pwm_dac4.sv
module pwm_dac4
    import pwm_dac_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DUTY_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    duty_wr,
    input  logic [$clog2(NCH)-1:0]  duty_ch,
    input  logic [DUTY_W-1:0]       duty_val,
    input  logic                    func_wr,
    input  logic [NCH-1:0]          func_val,
    input  logic                    port_wr,
    input  logic [NCH-1:0]          port_val,
    output logic [NCH-1:0]          pull_low
);
    localparam int SEL_W = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0] func;
        logic [NCH-1:0] port;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [DUTY_W-1:0] cnt;
    logic              wrap;
    logic [NCH-1:0]    pwm_low;

    pwm_period_ctr #(.CNT_W(DUTY_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic ld;
        assign ld = duty_wr && (duty_ch == SEL_W'(i));
        pwm_dac_chan #(.DUTY_W(DUTY_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (ld),
            .load_val(duty_val),
            .cnt     (cnt),
            .wrap    (wrap),
            .pwm_low (pwm_low[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (func_wr) st_d.func = func_val;
        if (port_wr) st_d.port = port_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.func <= {NCH{FN_PORT}};
            st_q.port <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            pull_low[i] = (st_q.func[i] == FN_PWM) ? pwm_low[i] : !st_q.port[i];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R8
        port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !func_wr && !port_wr && st_q.func[i] == FN_PORT)
            |=> $stable(pull_low[i]));
    end
endmodule

// File: tb/sim_pwm_dac4.sv
module sim_pwm_dac4;
    localparam int NCH = 4;
    localparam int DW  = 9;
    localparam int PER = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          duty_wr = 1'b0;
    logic [1:0]    duty_ch = '0;
    logic [DW-1:0] duty_val = '0;
    logic          func_wr = 1'b0;
    logic [3:0]    func_val = '0;
    logic          port_wr = 1'b0;
    logic [3:0]    port_val = '1;
    logic [3:0]    pull_low;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // bench model of the requirements
    int       m_cnt;
    int       m_sh[NCH];
    int       m_act[NCH];
    bit [3:0] m_func;
    bit [3:0] m_port;

    always #4 clk = ~clk;

    pwm_dac4 u0 (
        .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .duty_ch(duty_ch),
        .duty_val(duty_val), .func_wr(func_wr), .func_val(func_val),
        .port_wr(port_wr), .port_val(port_val), .pull_low(pull_low)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0;
            for (int i = 0; i < NCH; i++) begin m_sh[i] <= 0; m_act[i] <= 0; end
            m_func <= 4'h0;
            m_port <= 4'hF;
        end else begin
            m_cnt <= (m_cnt + 1) % PER;
            if (m_cnt == PER - 1)
                for (int i = 0; i < NCH; i++) m_act[i] <= m_sh[i];
            if (duty_wr) m_sh[duty_ch] <= int'(duty_val);
            if (func_wr) m_func <= func_val;
            if (port_wr) m_port <= port_val;
        end
    end

    function automatic bit exp_low(int ch);
        if (m_func[ch]) return (m_act[ch] == PER - 1) || (m_cnt < m_act[ch]);
        return !m_port[ch];
    endfunction

    task automatic check(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // lockstep comparison of every pin on every cycle
    always @(negedge clk) begin
        if (chk_en && !done) begin
            for (int i = 0; i < NCH; i++) begin
                string req;
                if (!m_func[i])                 req = "R8";
                else if (m_sh[i] != m_act[i])   req = "R4";
                else if (m_act[i] == PER - 1)   req = "R6";
                else                            req = "R5";
                check(req, int'(pull_low[i]), int'(exp_low(i)));
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic wr_duty(int ch, int v);
        duty_wr = 1'b1; duty_ch = 2'(ch); duty_val = DW'(v);
        tick();
        duty_wr = 1'b0;
    endtask

    task automatic wr_func(bit [3:0] v);
        func_wr = 1'b1; func_val = v; tick(); func_wr = 1'b0;
    endtask

    task automatic wr_port(bit [3:0] v);
        port_wr = 1'b1; port_val = v; tick(); port_wr = 1'b0;
    endtask

    task automatic wait_settled();
        bit same;
        do begin
            tick();
            same = 1'b1;
            for (int i = 0; i < NCH; i++) if (m_sh[i] != m_act[i]) same = 1'b0;
        end while (!same);
    endtask

    task automatic count_low(output int cnt[NCH]);
        for (int i = 0; i < NCH; i++) cnt[i] = 0;
        for (int k = 0; k < PER; k++) begin
            tick();
            for (int i = 0; i < NCH; i++) if (pull_low[i]) cnt[i]++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lows[NCH];
        int t0, t1;
        void'($urandom(32'd1234));
        repeat (4) tick();
        check("R2", int'(pull_low), 0);
        rst_n = 1'b1;
        tick();
        chk_en = 1'b1;
        check("R2", int'(pull_low), 0);

        // R8 port levels
        wr_port(4'b1010);
        check("R8", int'(pull_low), 4'b0101);
        wr_port(4'b1111);
        check("R8", int'(pull_low), 0);

        // R3 write to one channel only; R5 low count equals duty
        wr_func(4'b1111);
        wr_duty(2, 300);
        wait_settled();
        count_low(lows);
        check("R3", lows[0], 0);
        check("R3", lows[1], 0);
        check("R5", lows[2], 300);
        check("R3", lows[3], 0);

        // R6 full duty, R5 small duty
        wr_duty(0, 511);
        wr_duty(1, 1);
        wr_duty(3, 256);
        wait_settled();
        count_low(lows);
        check("R6", lows[0], 512);
        check("R5", lows[1], 1);
        check("R5", lows[3], 256);

        // R1 period: spacing of successive pull-low onsets on channel 3
        while (!(pull_low[3] == 1'b0)) tick();
        while (pull_low[3] == 1'b0) tick();
        t0 = int'($time / 8);
        while (pull_low[3] == 1'b1) tick();
        while (pull_low[3] == 1'b0) tick();
        t1 = int'($time / 8);
        check("R1", t1 - t0, PER);

        // R4 write in the wrap cycle waits a full extra period
        while (m_cnt != PER - 1) tick();
        duty_wr = 1'b1; duty_ch = 2'd2; duty_val = DW'(10);
        tick();
        duty_wr = 1'b0;
        check("R4", int'(pull_low[2]), 1);   // old duty 300, cnt 0
        repeat (20) tick();
        check("R4", int'(pull_low[2]), 1);   // cnt 20 still below old duty
        wait_settled();
        count_low(lows);
        check("R4", lows[2], 10);

        // R9 port write while in PWM is held, then shown in port mode
        wr_duty(1, 0);
        wait_settled();
        wr_port(4'b0000);
        check("R9", int'(pull_low[1]), 0);
        repeat (30) tick();
        check("R9", int'(pull_low[1]), 0);
        wr_func(4'b1101);
        check("R9", int'(pull_low[1]), 1);

        // R7 switch to PWM mid-period takes the active duty at once
        wr_port(4'b1111);
        while (m_cnt != 100) tick();
        wr_func(4'b1111);
        check("R7", int'(pull_low[0]), 1);   // duty 511
        check("R7", int'(pull_low[1]), 0);   // duty 0

        // random phase
        for (int n = 0; n < 20000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            duty_wr = 1'b0; func_wr = 1'b0; port_wr = 1'b0;
            if (r < 4) begin
                int v;
                duty_wr = 1'b1;
                duty_ch = 2'($urandom_range(0, 3));
                v = int'($urandom_range(0, 9));
                duty_val = (v == 0) ? DW'(0) : (v == 1) ? DW'(511) : DW'($urandom_range(0, 511));
            end else if (r < 5) begin
                func_wr = 1'b1; func_val = 4'($urandom_range(0, 15));
            end else if (r < 8) begin
                port_wr = 1'b1; port_val = 4'($urandom_range(0, 15));
            end
            tick();
        end
        duty_wr = 1'b0; func_wr = 1'b0; port_wr = 1'b0;
        tick();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule